// File: doc/BRIEF.md
# Nibble Data Memory Pointer and Access Unit

This unit sits beside the accumulator datapath of a small 4-bit controller and handles everything that touches data RAM. It keeps a short page register (X) and a nibble index register (Y). Together they form the indirect RAM address, which passes through a configurable address mask. It also keeps an 8-bit counter register that the accumulator can read or write one nibble at a time, and a counter-enable bit.

Each operation arrives as a 5-bit code with a 4-bit immediate and the current accumulator value. Most operations finish in the cycle they are issued. Loads and stores that step Y afterwards, and the read-modify-write operations on memory, hold `stall` high for one extra cycle. The unit reports accumulator writes and zero/carry flag updates as single-cycle strobes. The ALU and branching live elsewhere.

RAM is read combinationally: `ram_rdata` must reflect `ram_addr` within the same cycle. A write takes effect at the clock edge that ends the cycle in which `ram_wr` is high.

Top module: `dmem_access_unit`

## Requirements
- R1: While reset (`rst_n` low) is active and after it is released: X=0, Y=0, counter=0, `cnt_en`=0, `stall`=0, and neither `ram_rd` nor `ram_wr` is high until an operation is issued.
- R2: Indirect load (code 1) drives `ram_addr` = {X,Y} & ADDR_MASK with `ram_rd` high in the issue cycle. In that same cycle it raises `acc_we` with `acc_wdata`=`ram_rdata`, and raises `zf_we` with `zf_val`=1 exactly when the data is zero.
- R3: Direct load (code 2) and direct store (code 4) address location imm[1:0] (zero-extended), whatever X and Y hold.
- R4: Stores (codes 3 and 4) raise `ram_wr` for the issue cycle only, with `ram_wdata`=`acc_in`. `ram_rd` and `ram_wr` are never high together.
- R5: Code 9 loads X from imm[2:0] and code 10 loads Y from imm[3:0]. The new value is visible on `x_q`/`y_q` from the next cycle.
- R6: Code 11 increments Y and code 12 decrements Y, modulo 16. In the issue cycle each raises `zf_we` with `zf_val`=1 exactly when the new Y is zero.
- R7: Load-then-step (codes 5 up and 6 down) and store-then-step (codes 7 up and 8 down) access memory at the old {X,Y} in the issue cycle. They raise `stall` in the following cycle, step Y at the end of that cycle, and report Z of the new Y in it.
- R8: Memory increment (code 13) and decrement (code 14) read in the issue cycle. In the next cycle, with `stall` high, they write the low nibble of data±1 back to the same address. In that write cycle `cf_val` is bit 4 of the 5-bit result and `zf_val` is set when the low nibble is zero.
- R9: Set-bits (code 15) writes data|imm and clear-bits (code 16) writes data&~imm, both in the second cycle. Neither raises `zf_we` or `cf_we`.
- R10: Code 17 copies `acc_in` into counter[7:4] and code 18 copies it into counter[3:0]; the other nibble is kept. Code 19 (upper) and code 20 (lower) put a counter nibble on `acc_wdata` with `acc_we`, and set `zf_val` from it.
- R11: Code 21 sets `cnt_en` and code 22 clears it.
- R12: While `stall` is high, `op_valid`, `op_code` and `op_imm` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| op_imm | input | 4 | Immediate field |
| acc_in | input | 4 | Current accumulator value |
| stall | output | 1 | Second cycle of a two-cycle operation |
| ram_addr | output | 7 | Data RAM address |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_wdata | output | 4 | RAM write data |
| ram_rdata | input | 4 | RAM read data, combinational |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 4 | Accumulator write value |
| zf_we | output | 1 | Zero flag update strobe |
| zf_val | output | 1 | New zero flag |
| cf_we | output | 1 | Carry flag update strobe |
| cf_val | output | 1 | New carry flag |
| x_q | output | 3 | X register |
| y_q | output | 4 | Y register |
| cnt_q | output | 8 | Counter register |
| cnt_en | output | 1 | Counter enable bit |

## Verification
Every cycle, the assertions check four things. A second cycle never follows another second cycle. A read-modify-write writes back to the address it read. A carry strobe only follows a read, and the RAM strobes are never high together. They also check that a Y step moves Y by exactly one, that an X load takes the immediate, and that a half-counter write keeps the other nibble. Only the directed scenarios can show the actual data values: the masked address, the direct-address override, wrap-around of Y with its zero flag, a carry or borrow out of memory increment and decrement, the bit set and clear results, and that inputs presented during a stall are dropped.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

   typedef enum logic [4:0] {
      OP_NOP   = 5'd0,
      OP_LD    = 5'd1,
      OP_LDD   = 5'd2,
      OP_ST    = 5'd3,
      OP_STD   = 5'd4,
      OP_LDINC = 5'd5,
      OP_LDDEC = 5'd6,
      OP_STINC = 5'd7,
      OP_STDEC = 5'd8,
      OP_SETX  = 5'd9,
      OP_SETY  = 5'd10,
      OP_INCY  = 5'd11,
      OP_DECY  = 5'd12,
      OP_INCM  = 5'd13,
      OP_DECM  = 5'd14,
      OP_ORM   = 5'd15,
      OP_ANDNM = 5'd16,
      OP_A2CH  = 5'd17,
      OP_A2CL  = 5'd18,
      OP_CH2A  = 5'd19,
      OP_CL2A  = 5'd20,
      OP_CEN   = 5'd21,
      OP_CDIS  = 5'd22
   } dmp_op_e;

   typedef enum logic [1:0] {
      RMW_INC  = 2'd0,
      RMW_DEC  = 2'd1,
      RMW_OR   = 2'd2,
      RMW_ANDN = 2'd3
   } rmw_e;

endpackage

// File: rtl/dmp_ptr.sv
module dmp_ptr #(
   parameter int XW = 3,
   parameter int YW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_x,
   input  logic          ld_y,
   input  logic          step_up,
   input  logic          step_dn,
   input  logic [YW-1:0] imm,
   output logic [XW-1:0] x_q,
   output logic [YW-1:0] y_q,
   output logic [YW-1:0] y_stepped
);

   generate
      if (XW > YW) begin : g_bad_xw
         $error("dmp_ptr: X must not be wider than the immediate");
      end
   endgenerate

   assign y_stepped = step_dn ? (y_q - 1'b1) : (y_q + 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
      end else begin
         if (ld_x)
            x_q <= imm[XW-1:0];
         if (ld_y)
            y_q <= imm;
         else if (step_up || step_dn)
            y_q <= y_stepped;
      end
   end

   assert_y_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !ld_y) |=> (y_q == YW'($past(y_q) + 1'b1)));

   assert_y_step_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn && !ld_y) |=> (y_q == YW'($past(y_q) - 1'b1)));

   assert_x_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_x |=> (x_q == $past(imm[XW-1:0])));

endmodule

// File: rtl/dmp_cnt.sv
module dmp_cnt #(
   parameter int NW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_hi,
   input  logic            wr_lo,
   input  logic [NW-1:0]   din,
   input  logic            en_set,
   input  logic            en_clr,
   output logic [2*NW-1:0] cnt_q,
   output logic            en_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (wr_hi)
            cnt_q[2*NW-1:NW] <= din;
         if (wr_lo)
            cnt_q[NW-1:0] <= din;
         if (en_set)
            en_q <= 1'b1;
         else if (en_clr)
            en_q <= 1'b0;
      end
   end

   assert_hi_keeps_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo) |=> (cnt_q[NW-1:0] == $past(cnt_q[NW-1:0])));

   assert_lo_keeps_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (cnt_q[2*NW-1:NW] == $past(cnt_q[2*NW-1:NW])));

   assert_enable_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      en_set |=> en_q);

endmodule

// File: rtl/dmp_rmw.sv
module dmp_rmw
   import dmp_pkg::*;
#(
   parameter int DW = 4
) (
   input  rmw_e          mode,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] imm,
   output logic [DW:0]   res
);

   always_comb begin
      unique case (mode)
         RMW_INC:  res = {1'b0, din} + 1'b1;
         RMW_DEC:  res = {1'b0, din} - 1'b1;
         RMW_OR:   res = {1'b0, din | imm};
         default:  res = {1'b0, din & ~imm};
      endcase
   end

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit
   import dmp_pkg::*;
#(
   parameter int                    DW        = 4,
   parameter int                    XW        = 3,
   parameter int                    YW        = 4,
   parameter int                    DIR_BITS  = 2,
   parameter logic [XW+YW-1:0]      ADDR_MASK = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [4:0]          op_code,
   input  logic [DW-1:0]       op_imm,
   input  logic [DW-1:0]       acc_in,
   output logic                stall,
   output logic [XW+YW-1:0]    ram_addr,
   output logic                ram_rd,
   output logic                ram_wr,
   output logic [DW-1:0]       ram_wdata,
   input  logic [DW-1:0]       ram_rdata,
   output logic                acc_we,
   output logic [DW-1:0]       acc_wdata,
   output logic                zf_we,
   output logic                zf_val,
   output logic                cf_we,
   output logic                cf_val,
   output logic [XW-1:0]       x_q,
   output logic [YW-1:0]       y_q,
   output logic [2*DW-1:0]     cnt_q,
   output logic                cnt_en
);

   localparam int AW = XW + YW;

   generate
      if (YW != DW) begin : g_bad_yw
         $error("dmem_access_unit: Y width must equal the nibble width");
      end
      if (DIR_BITS > DW || DIR_BITS > AW) begin : g_bad_dir
         $error("dmem_access_unit: direct field too wide");
      end
   endgenerate

   logic          phase_q;
   dmp_op_e       pend_q;
   logic [DW-1:0] pimm_q;
   logic [DW-1:0] hold_q;

   dmp_op_e       cur;
   logic [DW-1:0] imm_c;
   logic          first;
   logic          two_cyc, is_direct, is_ld, is_st, is_rmw, is_arith;
   logic          step_up, step_dn;
   logic [YW-1:0] y_stepped;
   logic [AW-1:0] ptr_addr;
   logic [DW:0]   rmw_res;
   rmw_e          rmw_mode;

   assign first = !phase_q;
   assign cur   = phase_q ? pend_q : (op_valid ? dmp_op_e'(op_code) : OP_NOP);
   assign imm_c = phase_q ? pimm_q : op_imm;

   assign two_cyc   = cur inside {OP_LDINC, OP_LDDEC, OP_STINC, OP_STDEC,
                                  OP_INCM, OP_DECM, OP_ORM, OP_ANDNM};
   assign is_direct = cur inside {OP_LDD, OP_STD};
   assign is_ld     = first && (cur inside {OP_LD, OP_LDD, OP_LDINC, OP_LDDEC});
   assign is_st     = first && (cur inside {OP_ST, OP_STD, OP_STINC, OP_STDEC});
   assign is_rmw    = cur inside {OP_INCM, OP_DECM, OP_ORM, OP_ANDNM};
   assign is_arith  = cur inside {OP_INCM, OP_DECM};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         pend_q  <= OP_NOP;
         pimm_q  <= '0;
         hold_q  <= '0;
      end else if (first && two_cyc) begin
         phase_q <= 1'b1;
         pend_q  <= cur;
         pimm_q  <= op_imm;
         hold_q  <= ram_rdata;
      end else begin
         phase_q <= 1'b0;
      end
   end

   // address path: mask stage only when the mask trims bits
   generate
      if (ADDR_MASK == {AW{1'b1}}) begin : g_nomask
         assign ptr_addr = {x_q, y_q};
      end else begin : g_mask
         assign ptr_addr = {x_q, y_q} & ADDR_MASK;
      end
   endgenerate

   assign ram_addr = is_direct ? AW'(imm_c[DIR_BITS-1:0]) : ptr_addr;

   // pointer registers
   assign step_up = (phase_q && (cur inside {OP_LDINC, OP_STINC})) || (first && cur == OP_INCY);
   assign step_dn = (phase_q && (cur inside {OP_LDDEC, OP_STDEC})) || (first && cur == OP_DECY);

   dmp_ptr #(.XW(XW), .YW(YW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_x      (first && cur == OP_SETX),
      .ld_y      (first && cur == OP_SETY),
      .step_up   (step_up),
      .step_dn   (step_dn),
      .imm       (imm_c),
      .x_q       (x_q),
      .y_q       (y_q),
      .y_stepped (y_stepped)
   );

   // read-modify-write datapath
   always_comb begin
      unique case (cur)
         OP_INCM: rmw_mode = RMW_INC;
         OP_DECM: rmw_mode = RMW_DEC;
         OP_ORM:  rmw_mode = RMW_OR;
         default: rmw_mode = RMW_ANDN;
      endcase
   end

   dmp_rmw #(.DW(DW)) u_rmw (
      .mode (rmw_mode),
      .din  (hold_q),
      .imm  (imm_c),
      .res  (rmw_res)
   );

   // counter register
   dmp_cnt #(.NW(DW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hi  (first && cur == OP_A2CH),
      .wr_lo  (first && cur == OP_A2CL),
      .din    (acc_in),
      .en_set (first && cur == OP_CEN),
      .en_clr (first && cur == OP_CDIS),
      .cnt_q  (cnt_q),
      .en_q   (cnt_en)
   );

   // RAM strobes and data
   assign ram_rd    = is_ld || (first && is_rmw);
   assign ram_wr    = is_st || (phase_q && is_rmw);
   assign ram_wdata = phase_q ? rmw_res[DW-1:0] : acc_in;

   // accumulator and flag reporting
   assign acc_we = is_ld || (first && (cur inside {OP_CH2A, OP_CL2A}));

   always_comb begin
      if (is_ld)
         acc_wdata = ram_rdata;
      else if (cur == OP_CH2A)
         acc_wdata = cnt_q[2*DW-1:DW];
      else
         acc_wdata = cnt_q[DW-1:0];
   end

   assign zf_we = acc_we || step_up || step_dn || (phase_q && is_arith);

   always_comb begin
      if (acc_we)
         zf_val = (acc_wdata == '0);
      else if (step_up || step_dn)
         zf_val = (y_stepped == '0);
      else
         zf_val = (rmw_res[DW-1:0] == '0);
   end

   assign cf_we  = phase_q && is_arith;
   assign cf_val = rmw_res[DW];
   assign stall  = phase_q;

   assert_one_extra_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   assert_rmw_same_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && ram_wr) |-> (ram_addr == $past(ram_addr)));

   assert_carry_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cf_we |-> $past(ram_rd));

   assert_no_rd_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_rd && ram_wr));

endmodule

// File: tb/tb_dmem_access_unit.sv
module tb_dmem_access_unit;
   import dmp_pkg::*;

   localparam logic [6:0] MASK = 7'h3F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [3:0] op_imm = '0;
   logic [3:0] acc_in = '0;
   logic       stall;
   logic [6:0] ram_addr;
   logic       ram_rd, ram_wr;
   logic [3:0] ram_wdata, ram_rdata;
   logic       acc_we, zf_we, zf_val, cf_we, cf_val, cnt_en;
   logic [3:0] acc_wdata, y_q;
   logic [2:0] x_q;
   logic [7:0] cnt_q;

   logic [3:0] mem [0:127];

   int n_run = 0;
   int n_fail = 0;

   // snapshots of cycle one and cycle two of an operation
   logic       s1_rd, s1_wr, s1_awe, s1_zwe, s1_zv;
   logic [6:0] s1_addr;
   logic [3:0] s1_wd, s1_ad;
   logic       s2_stall, s2_wr, s2_zwe, s2_zv, s2_cwe, s2_cv;
   logic [6:0] s2_addr;
   logic [3:0] s2_wd;

   always #5 clk = ~clk;

   dmem_access_unit #(.ADDR_MASK(MASK)) dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_imm(op_imm), .acc_in(acc_in), .stall(stall), .ram_addr(ram_addr),
      .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .acc_we(acc_we), .acc_wdata(acc_wdata),
      .zf_we(zf_we), .zf_val(zf_val), .cf_we(cf_we), .cf_val(cf_val),
      .x_q(x_q), .y_q(y_q), .cnt_q(cnt_q), .cnt_en(cnt_en)
   );

   assign ram_rdata = mem[ram_addr];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) mem[i] <= '0;
      end else if (ram_wr) begin
         mem[ram_addr] <= ram_wdata;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_op(input dmp_op_e c, input logic [3:0] imm, input logic [3:0] acc,
                        input bit junk);
      @(negedge clk);
      op_valid = 1'b1; op_code = c; op_imm = imm; acc_in = acc;
      #1;
      s1_rd = ram_rd; s1_wr = ram_wr; s1_awe = acc_we; s1_ad = acc_wdata;
      s1_zwe = zf_we; s1_zv = zf_val; s1_addr = ram_addr; s1_wd = ram_wdata;
      @(negedge clk);
      if (junk) begin
         op_valid = 1'b1; op_code = OP_SETX; op_imm = 4'h7;
      end else begin
         op_valid = 1'b0;
      end
      #1;
      s2_stall = stall; s2_wr = ram_wr; s2_zwe = zf_we; s2_zv = zf_val;
      s2_cwe = cf_we; s2_cv = cf_val; s2_addr = ram_addr; s2_wd = ram_wdata;
      if (s2_stall) begin
         @(negedge clk);
         op_valid = 1'b0;
         #1;
      end
   endtask

   task automatic t_reset();
      check(x_q == 0 && y_q == 0, "R1 pointer reset", {x_q, y_q}, 0);
      check(cnt_q == 0 && !cnt_en, "R1 counter reset", {cnt_en, cnt_q}, 0);
      check(!stall && !ram_rd && !ram_wr, "R1 strobes idle", {stall, ram_rd, ram_wr}, 0);
   endtask

   task automatic t_pointer();
      do_op(OP_SETX, 4'hD, 4'h0, 0);
      check(x_q == 3'h5, "R5 X from imm[2:0]", x_q, 5);
      do_op(OP_SETY, 4'h9, 4'h0, 0);
      check(y_q == 4'h9 && x_q == 3'h5, "R5 Y from imm", {x_q, y_q}, 8'h59);
   endtask

   task automatic t_load_store();
      logic [6:0] a;
      a = {3'h5, 4'h9} & MASK;
      do_op(OP_ST, 4'h0, 4'hB, 0);
      check(s1_wr && !s1_rd && s1_addr == a && s1_wd == 4'hB, "R4 indirect store",
            {s1_wr, s1_addr, s1_wd}, {1'b1, a, 4'hB});
      check(!s2_wr && mem[a] == 4'hB, "R4 single write cycle", {s2_wr, mem[a]}, 4'hB);
      do_op(OP_LD, 4'h0, 4'h0, 0);
      check(s1_rd && s1_addr == a && s1_awe && s1_ad == 4'hB && s1_zwe && !s1_zv,
            "R2 masked load", {s1_addr, s1_ad, s1_zv}, {a, 4'hB, 1'b0});
      do_op(OP_SETY, 4'h8, 4'h0, 0);
      do_op(OP_LD, 4'h0, 4'h0, 0);
      check(s1_ad == 4'h0 && s1_zwe && s1_zv, "R2 zero load sets Z", {s1_ad, s1_zv}, 1);
   endtask

   task automatic t_direct();
      do_op(OP_STD, 4'hD, 4'h7, 0);
      check(s1_wr && s1_addr == 7'd1 && mem[1] == 4'h7, "R3 direct store",
            {s1_addr, mem[1]}, {7'd1, 4'h7});
      do_op(OP_LDD, 4'h5, 4'h0, 0);
      check(s1_rd && s1_addr == 7'd1 && s1_ad == 4'h7, "R3 direct load",
            {s1_addr, s1_ad}, {7'd1, 4'h7});
      do_op(OP_LDD, 4'hE, 4'h0, 0);
      check(s1_addr == 7'd2, "R3 direct addr imm[1:0]", s1_addr, 2);
   endtask

   task automatic t_ystep();
      do_op(OP_SETY, 4'hF, 4'h0, 0);
      do_op(OP_INCY, 4'h0, 4'h0, 0);
      check(y_q == 0 && s1_zwe && s1_zv, "R6 inc wraps sets Z", {y_q, s1_zv}, 1);
      do_op(OP_DECY, 4'h0, 4'h0, 0);
      check(y_q == 4'hF && s1_zwe && !s1_zv, "R6 dec wraps", {y_q, s1_zv}, 8'hF0 >> 3);
   endtask

   task automatic t_stepmem();
      logic [6:0] a;
      do_op(OP_SETX, 4'h2, 4'h0, 0);
      do_op(OP_SETY, 4'hF, 4'h0, 0);
      a = {3'h2, 4'hF} & MASK;
      do_op(OP_STINC, 4'h0, 4'h6, 0);
      check(s1_wr && s1_addr == a && mem[a] == 4'h6, "R7 store at old Y",
            {s1_addr, mem[a]}, {a, 4'h6});
      check(s2_stall && s2_zwe && s2_zv && y_q == 0, "R7 store-step Y wraps",
            {s2_stall, s2_zv, y_q}, {1'b1, 1'b1, 4'h0});
      do_op(OP_LDDEC, 4'h0, 4'h0, 0);
      check(s1_rd && s1_addr == ({3'h2, 4'h0} & MASK) && s1_awe, "R7 load at old Y",
            s1_addr, {3'h2, 4'h0} & MASK);
      check(s2_stall && s2_zwe && !s2_zv && y_q == 4'hF, "R7 load-step Y down",
            {s2_zv, y_q}, 4'hF);
   endtask

   task automatic t_rmw();
      logic [6:0] a;
      do_op(OP_SETX, 4'h1, 4'h0, 0);
      do_op(OP_SETY, 4'h3, 4'h0, 0);
      a = {3'h1, 4'h3} & MASK;
      do_op(OP_ST, 4'h0, 4'hF, 0);
      do_op(OP_INCM, 4'h0, 4'h0, 0);
      check(s1_rd && !s1_wr && s2_stall && s2_wr && s2_addr == a && s2_wd == 4'h0,
            "R8 inc write-back", {s2_addr, s2_wd}, {a, 4'h0});
      check(s2_cwe && s2_cv && s2_zwe && s2_zv, "R8 inc carry and Z",
            {s2_cv, s2_zv}, 2'b11);
      do_op(OP_DECM, 4'h0, 4'h0, 0);
      check(s2_wd == 4'hF && mem[a] == 4'hF && s2_cv && !s2_zv, "R8 dec borrow",
            {s2_wd, s2_cv, s2_zv}, {4'hF, 2'b10});
      do_op(OP_ST, 4'h0, 4'h3, 0);
      do_op(OP_INCM, 4'h0, 4'h0, 0);
      check(s2_wd == 4'h4 && s2_cwe && !s2_cv && !s2_zv, "R8 inc no carry",
            {s2_wd, s2_cv}, {4'h4, 1'b0});
   endtask

   task automatic t_bits();
      logic [6:0] a;
      a = {3'h1, 4'h3} & MASK;
      do_op(OP_ST, 4'h0, 4'h8, 0);
      do_op(OP_ORM, 4'h5, 4'h0, 0);
      check(s2_wr && mem[a] == 4'hD && !s2_zwe && !s2_cwe, "R9 set bits",
            {mem[a], s2_zwe, s2_cwe}, {4'hD, 2'b00});
      do_op(OP_ANDNM, 4'h4, 4'h0, 0);
      check(s2_wr && mem[a] == 4'h9 && !s2_zwe && !s2_cwe, "R9 clear bits",
            {mem[a], s2_zwe, s2_cwe}, {4'h9, 2'b00});
   endtask

   task automatic t_counter();
      do_op(OP_A2CH, 4'h0, 4'hA, 0);
      check(cnt_q == 8'hA0, "R10 write upper", cnt_q, 8'hA0);
      do_op(OP_A2CL, 4'h0, 4'h3, 0);
      check(cnt_q == 8'hA3, "R10 write lower keeps upper", cnt_q, 8'hA3);
      do_op(OP_CH2A, 4'h0, 4'h0, 0);
      check(s1_awe && s1_ad == 4'hA && s1_zwe && !s1_zv, "R10 read upper", s1_ad, 4'hA);
      do_op(OP_CL2A, 4'h0, 4'h0, 0);
      check(s1_awe && s1_ad == 4'h3 && !s1_zv, "R10 read lower", s1_ad, 4'h3);
      do_op(OP_A2CL, 4'h0, 4'h0, 0);
      do_op(OP_CL2A, 4'h0, 4'h0, 0);
      check(cnt_q == 8'hA0 && s1_zwe && s1_zv, "R10 zero nibble sets Z",
            {cnt_q, s1_zv}, {8'hA0, 1'b1});
   endtask

   task automatic t_enable();
      do_op(OP_CEN, 4'h0, 4'h0, 0);
      check(cnt_en, "R11 enable set", cnt_en, 1);
      do_op(OP_CDIS, 4'h0, 4'h0, 0);
      check(!cnt_en, "R11 enable clear", cnt_en, 0);
   endtask

   task automatic t_stall_ignore();
      do_op(OP_SETX, 4'h1, 4'h0, 0);
      do_op(OP_INCM, 4'h0, 4'h0, 1);
      check(s2_stall && x_q == 3'h1, "R12 op during stall ignored", x_q, 1);
      check(!stall, "R12 stall lasts one cycle", stall, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            #1;
            t_reset();
            @(negedge clk);
            rst_n = 1'b1;
            #1;
            t_reset();
            t_pointer();
            t_load_store();
            t_direct();
            t_ystep();
            t_stepmem();
            t_rmw();
            t_bits();
            t_counter();
            t_enable();
            t_stall_ignore();
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule